// File: doc/BRIEF.md
# Serial Display-Data Command Receiver

This block receives commands over a three-wire serial link (chip enable, serial clock and serial data) and turns them into the contents of a 126-bit segment display register and a set of drive-control fields. All three pins pass through two-flop synchronizers into the system clock. Edges of the serial clock and of chip enable are found in the system clock domain, so the block has a single clock.

A transfer starts with an eight-bit device address, shifted in while chip enable is low. If the address matches, chip enable is raised and a 56-bit frame follows. The frame holds 42 display bits, four fill bits, eight control bits and a two-bit tag. The tag names which third of the display register the frame replaces. Only the frame aimed at the lowest third also carries the control byte. Nothing changes until chip enable falls, and a frame that is malformed in any way leaves every register as it was. The serial clock may idle at either level between transfers.

Top module: `serial_lcd_loader`

## Requirements
- R1: The eight bits shifted in on serial-clock rising edges while chip enable is low form the address, with the first bit as bit 0. A frame is accepted only if at least eight such bits arrived and the last eight equal 0x42. Otherwise the frame that follows is ignored.
- R2: Bits are taken on serial-clock rising edges. Reception is identical whether the serial clock idles low or high between transfers.
- R3: While chip enable is high, the k-th data bit received (k = 1..42) is display bit k, which appears on `disp[k-1]`.
- R4: The frame tag is the 55th bit received (tag bit 1) followed by the 56th (tag bit 0). Tag 00 writes `disp[41:0]`, tag 01 writes `disp[83:42]` and tag 10 writes `disp[125:84]`. The other two thirds keep their values.
- R5: The frame is committed on the falling edge of chip enable, and only if exactly 56 bits were received and bits 43 to 46 (the fill bits) are all zero. Any other frame is discarded with no register change.
- R6: Frame bits 47 to 54, in arrival order, are S0, S1, K0, K1, P0, P1, SC and DR. They appear on the outputs as `sleep_ctl={S1,S0}`, `key_sel={K1,K0}`, `port_sel={P1,P0}`, `seg_on=SC` and `bias_third=DR`. They are updated only by a committed tag-00 frame.
- R7: A frame with tag 11 is discarded with no register change.
- R8: Reset (rst_n low) clears every display bit and every control output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Serial chip enable (low = address phase, high = data phase) |
| sck | input | 1 | Serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data |
| disp | output | 126 | Display register, disp[0] is display bit 1 |
| sleep_ctl | output | 2 | Sleep control {S1,S0} |
| key_sel | output | 2 | Key-scan versus segment output selection {K1,K0} |
| port_sel | output | 2 | Segment versus general-purpose port selection {P1,P0} |
| seg_on | output | 1 | Segments on/off |
| bias_third | output | 1 | 1/3 bias when set, 1/2 bias when clear |

## Verification
The hardest cases to reach from the pins are the frames that are almost valid: a correct address followed by 55 or 57 bits, an address phase of only seven bits, and a tag of 11. Each is built from the same vector table as the good frames, so a single field changes while the rest of the transfer stays correct. Display and control values written by earlier frames must then survive unchanged. The serial-clock idle level is a table column, which runs the same frames with the clock parked high and with it parked low.

// File: rtl/serial_lcd_loader.sv
module serial_lcd_loader #(
  parameter logic [7:0] DEV_ADDR = 8'h42,
  parameter int SEGS = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              sck,
  input  logic              sdi,
  output logic [3*SEGS-1:0] disp,
  output logic [1:0]        sleep_ctl,
  output logic [1:0]        key_sel,
  output logic [1:0]        port_sel,
  output logic              seg_on,
  output logic              bias_third
);
  localparam int FILL  = 4;
  localparam int CTRLW = 8;
  localparam int FRAME = SEGS + FILL + CTRLW + 2;
  localparam int CW    = $clog2(FRAME + 1) + 1;

  logic [2:0] ce_p, sck_p;
  logic [1:0] sdi_p;
  logic [7:0] addr_sr;
  logic [3:0] addr_cnt;
  logic       armed;
  logic [FRAME-1:0] sr;
  logic [CW-1:0]    cnt;
  logic [CTRLW-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_p <= '0; sck_p <= '0; sdi_p <= '0;
    end else begin
      ce_p  <= {ce_p[1:0], ce};
      sck_p <= {sck_p[1:0], sck};
      sdi_p <= {sdi_p[0], sdi};
    end

  wire ce_s     = ce_p[1];
  wire ce_rise  = ce_p[1] & ~ce_p[2];
  wire ce_fall  = ~ce_p[1] & ce_p[2];
  wire sck_rise = sck_p[1] & ~sck_p[2];
  wire bit_in   = sdi_p[1];

  wire [1:0] tag     = {sr[FRAME-2], sr[FRAME-1]};
  wire       fill_ok = sr[SEGS +: FILL] == '0;
  wire       commit  = ce_fall && armed && (cnt == CW'(FRAME)) && fill_ok && (tag != 2'b11);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_sr <= '0; addr_cnt <= '0; armed <= 1'b0; sr <= '0; cnt <= '0;
    end else begin
      if (sck_rise && !ce_s) begin
        addr_sr <= {bit_in, addr_sr[7:1]};
        if (addr_cnt != 4'd8) addr_cnt <= addr_cnt + 4'd1;
      end
      if (ce_rise) begin
        armed <= (addr_cnt == 4'd8) && (addr_sr == DEV_ADDR);
        cnt   <= '0;
      end
      if (sck_rise && ce_s && armed) begin
        sr <= {bit_in, sr[FRAME-1:1]};
        if (cnt != '1) cnt <= cnt + 1'b1;
      end
      if (ce_fall) begin
        armed    <= 1'b0;
        addr_cnt <= '0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      disp   <= '0;
      ctrl_q <= '0;
    end else if (commit) begin
      for (int i = 0; i < 3; i++)
        if (tag == 2'(i)) disp[i*SEGS +: SEGS] <= sr[SEGS-1:0];
      if (tag == 2'b00) ctrl_q <= sr[SEGS+FILL +: CTRLW];
    end

  assign sleep_ctl  = {ctrl_q[1], ctrl_q[0]};
  assign key_sel    = {ctrl_q[3], ctrl_q[2]};
  assign port_sel   = {ctrl_q[5], ctrl_q[4]};
  assign seg_on     = ctrl_q[6];
  assign bias_third = ctrl_q[7];

  a_r5_disp_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp) |-> $past(ce_fall));

  a_r6_ctrl_only_tag0: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(ce_fall && tag == 2'b00));

  a_r4_low_third_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && tag == 2'b01) |=> disp[SEGS-1:0] == $past(disp[SEGS-1:0]));

  a_r5_bad_length_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && cnt != CW'(FRAME)) |=> $stable(disp) && $stable(ctrl_q));

  a_r1_wrong_addr_not_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_rise && addr_sr != DEV_ADDR) |=> !armed);

  a_r7_tag3_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && tag == 2'b11) |=> $stable(disp) && $stable(ctrl_q));
endmodule

// File: tb/test_serial_lcd_loader.sv
module test_serial_lcd_loader;
  logic clk = 0, rst_n = 0, ce = 0, sck = 0, sdi = 0;
  logic [125:0] disp;
  logic [1:0] sleep_ctl, key_sel, port_sel;
  logic seg_on, bias_third;
  int checks = 0, errors = 0;
  localparam int H = 3;

  always #5 clk = ~clk;

  serial_lcd_loader i_serial_lcd_loader (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sck(sck), .sdi(sdi), .disp(disp),
    .sleep_ctl(sleep_ctl), .key_sel(key_sel), .port_sel(port_sel),
    .seg_on(seg_on), .bias_third(bias_third));

  // {idle_high, addr_bits, frame_bits, addr, tag, ctrl, data}
  localparam int NV = 11;
  localparam logic [70:0] VEC [NV] = '{
    {1'b0, 4'd8,  6'd56, 8'h42, 2'b00, 8'hA5, 42'h2_3456_789A_BC},
    {1'b0, 4'd8,  6'd56, 8'h42, 2'b01, 8'hFF, 42'h1_0F0F_0F0F_0F},
    {1'b1, 4'd8,  6'd56, 8'h42, 2'b10, 8'h00, 42'h3_FFFF_0000_01},
    {1'b1, 4'd8,  6'd56, 8'h42, 2'b00, 8'h3C, 42'h0_0000_0000_01},
    {1'b0, 4'd8,  6'd56, 8'h43, 2'b01, 8'h00, 42'h3_FFFF_FFFF_FF},
    {1'b0, 4'd7,  6'd56, 8'h42, 2'b01, 8'h00, 42'h3_FFFF_FFFF_FF},
    {1'b0, 4'd8,  6'd56, 8'h42, 2'b11, 8'hFF, 42'h3_FFFF_FFFF_FF},
    {1'b1, 4'd8,  6'd55, 8'h42, 2'b10, 8'h00, 42'h1_2121_2121_21},
    {1'b0, 4'd8,  6'd57, 8'h42, 2'b00, 8'h81, 42'h0_5555_5555_55},
    {1'b0, 4'd12, 6'd56, 8'h42, 2'b01, 8'h11, 42'h2_AAAA_5555_33},
    {1'b1, 4'd8,  6'd56, 8'h42, 2'b00, 8'h5A, 42'h1_8181_8181_81}
  };

  logic [125:0] m_disp = '0;
  logic [7:0]   m_ctrl = '0;

  function automatic logic [7:0] dut_ctrl();
    return {bias_third, seg_on, port_sel, key_sel, sleep_ctl};
  endfunction

  task automatic check(string req, logic [125:0] got, logic [125:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(logic b, logic idle_high);
    if (idle_high) begin
      sck = 0; sdi = b; wclk(H); sck = 1; wclk(H);
    end else begin
      sdi = b; wclk(H); sck = 1; wclk(H); sck = 0;
    end
  endtask

  task automatic send(logic idle_high, int abits, int nbits, logic [7:0] addr,
                      logic [1:0] tag, logic [7:0] ctl, logic [41:0] data);
    logic [55:0] f;
    f = {tag[0], tag[1], ctl, 4'b0000, data};
    ce = 0; sck = idle_high; wclk(H);
    for (int i = 8; i < abits; i++) put_bit(1'b1, idle_high);
    for (int i = 0; i < abits && i < 8; i++) put_bit(addr[i], idle_high);
    wclk(H); ce = 1; wclk(H);
    for (int i = 0; i < nbits; i++) put_bit(i < 56 ? f[i] : 1'b0, idle_high);
    wclk(H); ce = 0; wclk(2*H + 4);
  endtask

  task automatic model(int abits, int nbits, logic [7:0] addr, logic [1:0] tag,
                       logic [7:0] ctl, logic [41:0] data);
    if (abits >= 8 && addr == 8'h42 && nbits == 56 && tag != 2'b11) begin
      m_disp[tag*42 +: 42] = data;
      if (tag == 2'b00) m_ctrl = ctl;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wclk(3);
    check("R8 reset disp", disp, '0);
    check("R8 reset ctrl", 126'(dut_ctrl()), '0);
    rst_n = 1; wclk(3);

    for (int v = 0; v < NV; v++) begin
      logic idle; logic [3:0] ab; logic [5:0] nb; logic [7:0] ad;
      logic [1:0] tg; logic [7:0] ct; logic [41:0] dt; string req;
      {idle, ab, nb, ad, tg, ct, dt} = VEC[v];
      send(idle, ab, nb, ad, tg, ct, dt);
      model(ab, nb, ad, tg, ct, dt);
      if (ad != 8'h42 || ab < 8) req = "R1";
      else if (tg == 2'b11) req = "R7";
      else if (nb != 56) req = "R5";
      else if (idle) req = "R2";
      else req = "R4";
      check($sformatf("%s vector %0d disp", req, v), disp, m_disp);
      check($sformatf("R6 vector %0d ctrl", v), 126'(dut_ctrl()), 126'(m_ctrl));
    end

    // R3: only D42 set lands on disp[41]
    send(1'b0, 8, 56, 8'h42, 2'b00, 8'h00, 42'h200_0000_0000);
    model(8, 56, 8'h42, 2'b00, 8'h00, 42'h200_0000_0000);
    check("R3 last display bit position", 126'(disp[41]), 126'(1'b1));
    check("R3 frame order", disp, m_disp);

    // R6: individual field mapping, S1 and DR set
    send(1'b1, 8, 56, 8'h42, 2'b00, 8'h82, 42'h0);
    check("R6 sleep_ctl", 126'(sleep_ctl), 126'(2'b10));
    check("R6 bias_third", 126'(bias_third), 126'(1'b1));

    rst_n = 0; wclk(2);
    check("R8 reset clears disp", disp, '0);
    check("R8 reset clears ctrl", 126'(dut_ctrl()), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule